// File: doc/BRIEF.md
# Bank-Interleaved DRAM Command Sequencer

This block issues a repeating stream of DRAM commands that works through eight banks in turn. Each bank gets an activate, and the read with auto-precharge to that bank follows in the very next slot. Every other slot is a deselect. One command slot is produced per clock. Activates are delayed only as long as three timing limits require:

- the minimum gap between any two activates;
- the rolling window that may hold at most four activates;
- the row cycle time between two activates to the same bank.

The three limits are given in clock cycles on run-time inputs. The block captures them only while it is disabled. When enable drops, the block still issues any read that is owed to an opened bank and then idles on deselects. When enable returns, the block starts again at bank 0 with no timing history.

The block drives a load-generation or soak-test pattern onto a memory command bus. Reads always use a burst length of 8, so the block needs no burst control.

Top module: `act_interleave_seq`

## Requirements
- R1: Activates address the banks in ascending order 0,1,...,7 and then wrap to 0.
- R2: Every activate (code 01) is followed in the next slot by a read with auto-precharge (code 10) to the same bank.
- R3: Every slot that holds neither an activate nor a read is a deselect (code 00). During a deselect the bank output keeps its previous value and the valid strobe is low.
- R4: The gap between two consecutive activates, counted in slots, is never below the captured activate-to-activate limit.
- R5: The fifth activate comes no sooner than the captured window length after the first of the four activates before it. A 16-cycle window with a 4-cycle gap adds no padding. A 20-cycle window with a 4-cycle gap adds four deselects.
- R6: Two activates to the same bank are at least the captured row cycle time apart.
- R7: Code 11 never appears. The valid strobe is high exactly when the code is not 00.
- R8: Once enable is seen low at a clock edge, no further activate is issued. A read still owed to the last activated bank is still issued.
- R9: The limit inputs are captured only while the block is disabled, so changes made while it runs have no effect. After re-enable the first activate goes to bank 0 with all timing history cleared.
- R10: A limit value below 2 is treated as 2.
- R11: An activate is issued in the first slot that all limits and the pending read allow, so no deselect is added beyond what the limits need.
- R12: During and straight after reset the outputs show a deselect, bank 0 and a low valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one command slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| rrd_lim_i | input | 8 | Activate-to-activate limit in cycles |
| faw_lim_i | input | 8 | Four-activate window length in cycles |
| rc_lim_i | input | 8 | Same-bank activate spacing in cycles |
| cmd_o | output | 2 | Command code: 00 deselect, 01 activate, 10 read with auto-precharge |
| bank_o | output | 3 | Bank index, meaningful for non-deselect codes |
| cmd_vld_o | output | 1 | High in slots holding an activate or a read |

## Verification
The bench builds the block with its default parameters: eight banks, 8-bit limit counters and a four-entry window history. With these defaults, window lengths up to 255 cycles can be reached, which covers cases where the window, the pairwise gap or the row cycle time is the binding limit. The runs use several limit sets: one where the window adds no padding, one where it pads, one where the row cycle time dominates, and one where every limit is clamped to 2. Enable is dropped right after an activate to reach the owed-read case. Limits are changed while the block runs, and the block is re-enabled part way through a bank sweep.

// File: rtl/act_interleave_pkg.sv
package act_interleave_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_ACT   = 2'b01,
    CMD_RDA   = 2'b10
  } cmd_e;

  localparam int unsigned LIM_FLOOR = 2;
endpackage

// File: rtl/act_interleave_limits.sv
module act_interleave_limits #(
  parameter int unsigned W    = 8,
  parameter int unsigned NLIM = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [NLIM-1:0][W-1:0]  lim_i,
  output logic [NLIM-1:0][W-1:0]  lim_o
);
  import act_interleave_pkg::*;
  localparam logic [W-1:0] FLOOR = W'(LIM_FLOOR);

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= FLOOR;
      else if (load_i) q <= (lim_i[g] < FLOOR) ? FLOOR : lim_i[g];
    end
    assign lim_o[g] = q;
  end
endmodule

// File: rtl/act_interleave_hist.sv
// Ages of the most recent activates; entry 0 is the newest.
module act_interleave_hist #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         act_i,
  input  logic [W-1:0] rrd_lim_i,
  input  logic [W-1:0] faw_lim_i,
  output logic         rrd_ok_o,
  output logic         faw_ok_o
);
  localparam logic [W-1:0] AGE_MAX = '1;
  logic [DEPTH-1:0][W-1:0] age_q;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] a);
    return (a == AGE_MAX) ? a : a + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     age_q[g] <= AGE_MAX;
      else if (clr_i)  age_q[g] <= AGE_MAX;
      else if (act_i) begin
        if (g == 0) age_q[g] <= W'(1);
        else        age_q[g] <= sat_inc(age_q[(g == 0) ? 0 : g-1]);
      end else      age_q[g] <= sat_inc(age_q[g]);
    end
  end

  assign rrd_ok_o = age_q[0] >= rrd_lim_i;
  assign faw_ok_o = age_q[DEPTH-1] >= faw_lim_i;
endmodule

// File: rtl/act_interleave_rc.sv
// Per-bank age since that bank's last activate.
module act_interleave_rc #(
  parameter int unsigned W      = 8,
  parameter int unsigned NBANK  = 8,
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              act_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [W-1:0]      rc_lim_i,
  output logic              rc_ok_o
);
  localparam logic [W-1:0] AGE_MAX = '1;
  logic [NBANK-1:0][W-1:0] age_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  age_q[b] <= AGE_MAX;
      else if (clr_i)                               age_q[b] <= AGE_MAX;
      else if (act_i && bank_i == BANK_W'(b))       age_q[b] <= W'(1);
      else if (age_q[b] != AGE_MAX)                 age_q[b] <= age_q[b] + 1'b1;
    end
  end

  assign rc_ok_o = age_q[bank_i] >= rc_lim_i;
endmodule

// File: rtl/act_interleave_seq.sv
module act_interleave_seq #(
  parameter int unsigned NBANK    = 8,
  parameter int unsigned LIM_W    = 8,
  parameter int unsigned WIN_ACTS = 4,
  localparam int unsigned BANK_W  = $clog2(NBANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LIM_W-1:0]  rrd_lim_i,
  input  logic [LIM_W-1:0]  faw_lim_i,
  input  logic [LIM_W-1:0]  rc_lim_i,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              cmd_vld_o
);
  import act_interleave_pkg::*;

  localparam int unsigned NLIM = 3;
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NBANK - 1);

  logic                        run_q, rd_pend_q;
  logic [BANK_W-1:0]           rd_bank_q, ptr_q, bank_q;
  cmd_e                        cmd_q;
  logic [NLIM-1:0][LIM_W-1:0]  lim_raw, lim_q;
  logic [LIM_W-1:0]            trrd_q, tfaw_q, trc_q;
  logic                        rrd_ok, faw_ok, rc_ok, act_go, clr;

  assign lim_raw = {rc_lim_i, faw_lim_i, rrd_lim_i};
  assign trrd_q  = lim_q[0];
  assign tfaw_q  = lim_q[1];
  assign trc_q   = lim_q[2];
  assign clr     = !run_q;

  act_interleave_limits #(.W(LIM_W), .NLIM(NLIM)) u_lim (
    .clk_i, .rst_ni, .load_i(clr), .lim_i(lim_raw), .lim_o(lim_q)
  );

  act_interleave_hist #(.W(LIM_W), .DEPTH(WIN_ACTS)) u_hist (
    .clk_i, .rst_ni, .clr_i(clr), .act_i(act_go),
    .rrd_lim_i(trrd_q), .faw_lim_i(tfaw_q),
    .rrd_ok_o(rrd_ok), .faw_ok_o(faw_ok)
  );

  act_interleave_rc #(.W(LIM_W), .NBANK(NBANK), .BANK_W(BANK_W)) u_rc (
    .clk_i, .rst_ni, .clr_i(clr), .act_i(act_go), .bank_i(ptr_q),
    .rc_lim_i(trc_q), .rc_ok_o(rc_ok)
  );

  assign act_go = run_q && en_i && !rd_pend_q && rrd_ok && faw_ok && rc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_bank_q <= '0;
      ptr_q     <= '0;
      cmd_q     <= CMD_DESEL;
      bank_q    <= '0;
    end else begin
      run_q     <= en_i;
      rd_pend_q <= act_go;
      if (act_go) rd_bank_q <= ptr_q;
      if (!run_q)      ptr_q <= '0;
      else if (act_go) ptr_q <= (ptr_q == LAST_BANK) ? '0 : ptr_q + 1'b1;
      if (rd_pend_q) begin
        cmd_q  <= CMD_RDA;
        bank_q <= rd_bank_q;
      end else if (act_go) begin
        cmd_q  <= CMD_ACT;
        bank_q <= ptr_q;
      end else begin
        cmd_q  <= CMD_DESEL;
      end
    end
  end

  assign cmd_o     = cmd_q;
  assign bank_o    = bank_q;
  assign cmd_vld_o = cmd_q != CMD_DESEL;
endmodule

// File: rtl/act_interleave_chk.sv
module act_interleave_chk #(
  parameter int unsigned NBANK  = 8,
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned BANK_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [1:0]        cmd_o,
  input logic [BANK_W-1:0] bank_o,
  input logic              cmd_vld_o,
  input logic [LIM_W-1:0]  trrd_q
);
  localparam logic [1:0] C_DESEL = 2'b00, C_ACT = 2'b01, C_RDA = 2'b10;
  localparam logic [LIM_W-1:0] GAP_MAX = '1;
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NBANK - 1);

  logic              seen_q;
  logic [BANK_W-1:0] last_q;
  logic [LIM_W-1:0]  gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
      gap_q  <= GAP_MAX;
    end else begin
      if (!en_i) seen_q <= 1'b0;
      else if (cmd_o == C_ACT) seen_q <= 1'b1;
      if (cmd_o == C_ACT) begin
        last_q <= bank_o;
        gap_q  <= LIM_W'(1);
      end else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end
  end

  // R1 R9
  bank_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_ACT |-> bank_o == (seen_q ? ((last_q == LAST_BANK) ? '0 : last_q + 1'b1) : '0));

  // R2
  act_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_ACT |=> (cmd_o == C_RDA && bank_o == $past(bank_o)));

  // R3
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_DESEL |-> (!cmd_vld_o && $stable(bank_o)));

  // R7
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o == (cmd_o == C_ACT || cmd_o == C_RDA));

  // R4
  rrd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_ACT && seen_q) |-> gap_q >= trrd_q);

  // R8
  no_act_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cmd_o != C_ACT);
endmodule

bind act_interleave_seq act_interleave_chk #(
  .NBANK(NBANK), .LIM_W(LIM_W), .BANK_W(BANK_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cmd_o(cmd_o),
  .bank_o(bank_o), .cmd_vld_o(cmd_vld_o), .trrd_q(trrd_q)
);

// File: tb/act_interleave_seq_test.sv
module act_interleave_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] rrd = 8'd4, faw = 8'd16, rc = 8'd10;
  logic [1:0] cmd;
  logic [2:0] bank;
  logic       vld;

  int compared = 0, mismatched = 0;
  string phase = "R12";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  act_interleave_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .rrd_lim_i(rrd), .faw_lim_i(faw), .rc_lim_i(rc),
    .cmd_o(cmd), .bank_o(bank), .cmd_vld_o(vld)
  );

  // behavioural reference: timestamps of activates, not ages
  int cyc, m_cmd, m_bank, m_ptr, m_pbank, lr, lf, lc;
  bit m_run, m_pend, go;
  int q[$];
  int blast[NB];

  function automatic int clamp2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic bit limits_ok();
    if (q.size() > 0 && cyc - q[q.size()-1] < lr) return 0;
    if (q.size() >= 4 && cyc - q[q.size()-4] < lf) return 0;
    if (blast[m_ptr] >= 0 && cyc - blast[m_ptr] < lc) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; m_cmd = 0; m_bank = 0; m_ptr = 0; m_pbank = 0;
      m_run = 0; m_pend = 0; lr = 2; lf = 2; lc = 2;
      q.delete();
      for (int i = 0; i < NB; i++) blast[i] = -1;
    end else begin
      cyc++;
      go = m_run && en && !m_pend && limits_ok();
      if (m_pend) begin m_cmd = 2; m_bank = m_pbank; end
      else if (go) begin m_cmd = 1; m_bank = m_ptr; end
      else m_cmd = 0;
      if (go) begin
        q.push_back(cyc);
        if (q.size() > 4) void'(q.pop_front());
        blast[m_ptr] = cyc;
        m_pbank = m_ptr;
      end
      m_pend = go;
      if (!m_run) begin
        m_ptr = 0;
        lr = clamp2(rrd); lf = clamp2(faw); lc = clamp2(rc);
        q.delete();
        for (int i = 0; i < NB; i++) blast[i] = -1;
      end else if (go) m_ptr = (m_ptr + 1) % NB;
      m_run = en;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (cmd !== 2'(m_cmd) || bank !== 3'(m_bank) || vld !== (m_cmd != 0)) begin
        mismatched++;
        $display("FAIL %s @%0t: cmd=%0d bank=%0d vld=%0d expected cmd=%0d bank=%0d vld=%0d",
                 phase, $time, cmd, bank, vld, m_cmd, m_bank, m_cmd != 0);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_act();
    for (int i = 0; i < 200 && cmd != 2'b01; i++) @(negedge clk);
  endtask

  task automatic run_set(input int r, input int f, input int c, input int n, input string tag);
    en = 1'b0; phase = tag;
    rrd = 8'(r); faw = 8'(f); rc = 8'(c);
    cycles(3);
    en = 1'b1;
    cycles(n);
    en = 1'b0;
    cycles(4);
  endtask

  initial begin
    cycles(3);
    // R12: reset state
    chk(cmd == 2'b00 && !vld && bank == 3'd0, "R12 reset", {cmd, bank}, 0);
    rst_n = 1'b1;
    cycles(2);
    chk(cmd == 2'b00 && !vld, "R12 after reset", cmd, 0);

    // R1 R2 R3 R4 R7 R11: 16-cycle window, no padding
    run_set(4, 16, 10, 120, "R1/R2/R3/R4/R7/R11");
    // R5: window forces padding
    run_set(4, 20, 10, 120, "R5/R11");
    run_set(6, 30, 10, 120, "R4/R5");
    // R6: row cycle time dominates
    run_set(4, 16, 40, 140, "R6/R11");
    // R10: clamped limits, activate every second slot
    run_set(0, 1, 0, 60, "R10");

    // R8: drop enable right after an activate
    phase = "R8"; rrd = 8'd4; faw = 8'd16; rc = 8'd10;
    cycles(2); en = 1'b1;
    cycles(7); wait_act();
    en = 1'b0;
    @(negedge clk);
    chk(cmd == 2'b10, "R8 owed read", cmd, 2);
    cycles(10);
    chk(cmd == 2'b00 && !vld, "R8 idle", cmd, 0);

    // R9: limits changed while running are ignored; restart at bank 0
    phase = "R9"; rrd = 8'd5; faw = 8'd25; rc = 8'd12;
    cycles(2); en = 1'b1;
    cycles(20);
    rrd = 8'd2; faw = 8'd2; rc = 8'd2;
    cycles(60);
    en = 1'b0; cycles(2); en = 1'b1;
    wait_act();
    chk(bank == 3'd0, "R9 restart bank", bank, 0);
    cycles(40);
    en = 1'b0; cycles(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule